// File: doc/BRIEF.md
# Stereo PDM Receiver with Channel Selection

This block receives a one-bit pulse-density audio stream that carries two channels on a single data wire, together with its bit clock. Both wires are brought into a faster system clock domain, where the bit clock's transitions are found by comparing successive synchronized levels. A bit taken on a rising transition belongs to the left channel; a bit taken on a falling transition belongs to the right channel. The two channels always alternate, left then right.

A two-bit mode input picks what goes downstream: the left channel alone, the right channel alone, the halved sum of a left/right pair, or nothing (off). Every produced sample is a two-bit signed-step code with a one-cycle valid strobe, meant for a decimating converter further down the chip. At the same time the block times the bit clock over a fixed number of rising transitions and sorts it into a low band, a high band, or unsupported. The halved-sum mode is refused when the clock sits in the high band.

Top module: `pdm_stereo_rx`

## Requirements
- R1: While reset is high and in the first cycle after it, `smp_valid_o` is 0, `rate_bad_o` is 1 and `mix_reject_o` is 0.
- R2: A bit-clock level change first captured at system clock edge n drives any resulting strobe high in the cycle after edge n+2. Sample codes are 00 for -1, 01 for 0 and 10 for +1; 11 never appears.
- R3: With `mode_i` = 01 (left), each rising bit-clock transition strobes one sample, code 10 if the data bit was 1 and 00 if it was 0; falling transitions produce no strobe.
- R4: With `mode_i` = 10 (right), each falling transition strobes one sample with the same bit-to-code rule; rising transitions produce no strobe.
- R5: With `mode_i` = 11 (mix), each falling transition that follows a captured left bit strobes the code equal to left bit plus right bit (00, 01 or 10); rising transitions produce no strobe.
- R6: `mix_reject_o` is 1 exactly when `mode_i` is 11 and the measured band is high; while the band is high, mix mode produces no strobe.
- R7: With `mode_i` = 00 (off), no strobe is produced and the captured left bit and the rate measurement are cleared, so `rate_bad_o` stays 1 after leaving off until a full new window has been timed.
- R8: The rate is judged over MEAS_EDGES bit-clock periods between rising transitions: a span of LO_MIN..LO_MAX system cycles is the low band, HI_MIN..HI_MAX is the high band, anything else sets `rate_bad_o`. The verdict changes in the cycle after the closing rising transition is detected.
- R9: If more than LO_MAX system cycles pass inside an open window without it closing (slow or stopped bit clock), `rate_bad_o` goes to 1 without waiting for the window to close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the bit clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pdm_clk_i | input | 1 | Asynchronous PDM bit clock |
| pdm_dat_i | input | 1 | Asynchronous interleaved stereo PDM data |
| mode_i | input | 2 | 00 off, 01 left, 10 right, 11 halved sum |
| smp_valid_o | output | 1 | One-cycle strobe for a new sample |
| smp_code_o | output | 2 | Sample code: 00 = -1, 01 = 0, 10 = +1 |
| rate_bad_o | output | 1 | Bit clock outside both supported bands or not yet measured |
| mix_reject_o | output | 1 | Halved-sum mode requested while in the high band |

## Verification
The rising transition that closes a measurement window is also a left-bit capture, so the band verdict and a left-mode strobe land on the same register update, and in mix mode a band change on that rising edge decides whether the very next falling edge may strobe. The bench provokes this by moving the bit clock from the low band straight into the high band while mix mode is active, and from the high band into the gap between bands while left mode runs. A behavioural model tracking rise times in integers judges every cycle, gating each mix strobe with the band it held before the falling transition.

// File: rtl/pdm_rx_pkg.sv
package pdm_rx_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_LEFT  = 2'b01,
        MODE_RIGHT = 2'b10,
        MODE_MIX   = 2'b11
    } rx_mode_e;

    typedef enum logic [1:0] {
        BAND_NONE = 2'b00,
        BAND_LOW  = 2'b01,
        BAND_HIGH = 2'b10
    } rate_band_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic bit_v;
    } edge_evt_t;

endpackage

// File: rtl/pdm_edge_sync.sv
module pdm_edge_sync
    import pdm_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      pdm_clk_i,
    input  logic      pdm_dat_i,
    output edge_evt_t evt_o
);

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] clk_pipe;
        logic [SYNC_STAGES-1:0] dat_pipe;
        logic                   prev;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.clk_pipe = {s_q.clk_pipe[TOP-1:0], pdm_clk_i};
        s_d.dat_pipe = {s_q.dat_pipe[TOP-1:0], pdm_dat_i};
        s_d.prev     = s_q.clk_pipe[TOP];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    always_comb begin
        evt_o.rise  = s_q.clk_pipe[TOP] & ~s_q.prev;
        evt_o.fall  = ~s_q.clk_pipe[TOP] & s_q.prev;
        evt_o.bit_v = s_q.dat_pipe[TOP];
    end

endmodule

// File: rtl/pdm_rate_meter.sv
module pdm_rate_meter
    import pdm_rx_pkg::*;
#(
    parameter int MEAS_EDGES = 4,
    parameter int LO_MIN     = 40,
    parameter int LO_MAX     = 80,
    parameter int HI_MIN     = 16,
    parameter int HI_MAX     = 30
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       clear_i,
    input  logic       rise_i,
    output rate_band_e band_o
);

    localparam int CNT_W  = $clog2(LO_MAX + 3);
    localparam int EDGE_W = $clog2(MEAS_EDGES + 1);
    localparam logic [CNT_W-1:0]  LO_MIN_C = CNT_W'(LO_MIN);
    localparam logic [CNT_W-1:0]  LO_MAX_C = CNT_W'(LO_MAX);
    localparam logic [CNT_W-1:0]  HI_MIN_C = CNT_W'(HI_MIN);
    localparam logic [CNT_W-1:0]  HI_MAX_C = CNT_W'(HI_MAX);
    localparam logic [EDGE_W-1:0] LAST_C   = EDGE_W'(MEAS_EDGES - 1);

    typedef struct packed {
        logic              armed;
        logic [CNT_W-1:0]  cnt;
        logic [EDGE_W-1:0] edges;
        rate_band_e        band;
    } meter_state_t;

    meter_state_t s_d, s_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] span;

    function automatic rate_band_e classify(input logic [CNT_W-1:0] v);
        if (v >= LO_MIN_C && v <= LO_MAX_C)      return BAND_LOW;
        else if (v >= HI_MIN_C && v <= HI_MAX_C) return BAND_HIGH;
        else                                     return BAND_NONE;
    endfunction

    always_comb begin
        s_d     = s_q;
        cnt_inc = (s_q.cnt <= LO_MAX_C) ? s_q.cnt + 1'b1 : s_q.cnt;
        span    = s_q.cnt + 1'b1;
        if (clear_i) begin
            s_d = '0;
        end else if (rise_i) begin
            if (!s_q.armed) begin
                s_d.armed = 1'b1;
                s_d.cnt   = '0;
                s_d.edges = '0;
            end else if (s_q.edges == LAST_C) begin
                s_d.band  = classify(span);
                s_d.cnt   = '0;
                s_d.edges = '0;
            end else begin
                s_d.edges = s_q.edges + 1'b1;
                s_d.cnt   = cnt_inc;
            end
        end else if (s_q.armed) begin
            s_d.cnt = cnt_inc;
            if (s_q.cnt >= LO_MAX_C) s_d.band = BAND_NONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign band_o = s_q.band;

endmodule

// File: rtl/pdm_chan_split.sv
module pdm_chan_split
    import pdm_rx_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  rx_mode_e   mode_i,
    input  edge_evt_t  evt_i,
    input  rate_band_e band_i,
    output logic       valid_o,
    output logic [1:0] code_o
);

    typedef struct packed {
        logic       left_bit;
        logic       have_left;
        logic       valid;
        logic [1:0] code;
    } split_state_t;

    split_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        if (mode_i == MODE_OFF) begin
            s_d = '0;
        end else begin
            if (evt_i.rise) begin
                s_d.left_bit  = evt_i.bit_v;
                s_d.have_left = 1'b1;
                if (mode_i == MODE_LEFT) begin
                    s_d.valid = 1'b1;
                    s_d.code  = {evt_i.bit_v, 1'b0};
                end
            end
            if (evt_i.fall) begin
                s_d.have_left = 1'b0;
                if (mode_i == MODE_RIGHT) begin
                    s_d.valid = 1'b1;
                    s_d.code  = {evt_i.bit_v, 1'b0};
                end else if (mode_i == MODE_MIX && s_q.have_left && band_i != BAND_HIGH) begin
                    s_d.valid = 1'b1;
                    s_d.code  = {1'b0, s_q.left_bit} + {1'b0, evt_i.bit_v};
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign valid_o = s_q.valid;
    assign code_o  = s_q.code;

endmodule

// File: rtl/pdm_stereo_rx.sv
module pdm_stereo_rx
    import pdm_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MEAS_EDGES  = 4,
    parameter int LO_MIN      = 40,
    parameter int LO_MAX      = 80,
    parameter int HI_MIN      = 16,
    parameter int HI_MAX      = 30
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       pdm_clk_i,
    input  logic       pdm_dat_i,
    input  logic [1:0] mode_i,
    output logic       smp_valid_o,
    output logic [1:0] smp_code_o,
    output logic       rate_bad_o,
    output logic       mix_reject_o
);

    rx_mode_e   mode;
    edge_evt_t  evt;
    rate_band_e band;

    assign mode = rx_mode_e'(mode_i);

    pdm_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .pdm_clk_i(pdm_clk_i),
        .pdm_dat_i(pdm_dat_i),
        .evt_o    (evt)
    );

    pdm_rate_meter #(
        .MEAS_EDGES(MEAS_EDGES),
        .LO_MIN    (LO_MIN),
        .LO_MAX    (LO_MAX),
        .HI_MIN    (HI_MIN),
        .HI_MAX    (HI_MAX)
    ) u_meter (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clear_i(mode == MODE_OFF),
        .rise_i (evt.rise),
        .band_o (band)
    );

    pdm_chan_split u_split (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .mode_i (mode),
        .evt_i  (evt),
        .band_i (band),
        .valid_o(smp_valid_o),
        .code_o (smp_code_o)
    );

    assign rate_bad_o   = (band == BAND_NONE);
    assign mix_reject_o = (mode == MODE_MIX) && (band == BAND_HIGH);

endmodule

// File: rtl/pdm_rx_checker.sv
module pdm_rx_checker (
    input logic       clk_i,
    input logic       rst_i,
    input logic [1:0] mode_i,
    input logic       smp_valid_o,
    input logic [1:0] smp_code_o,
    input logic       rate_bad_o,
    input logic       mix_reject_o
);

    assert_off_quiet_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 2'b00) |=> (!smp_valid_o && rate_bad_o));

    assert_reject_blocks_mix_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        mix_reject_o |=> !smp_valid_o);

    assert_code_legal_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        smp_valid_o |-> (smp_code_o != 2'b11));

    assert_single_code_even_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp_valid_o && $past(mode_i) != 2'b11) |-> !smp_code_o[0]);

    assert_reject_needs_rate_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        mix_reject_o |-> !rate_bad_o);

endmodule

bind pdm_stereo_rx pdm_rx_checker u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .mode_i      (mode_i),
    .smp_valid_o (smp_valid_o),
    .smp_code_o  (smp_code_o),
    .rate_bad_o  (rate_bad_o),
    .mix_reject_o(mix_reject_o)
);

// File: tb/sim_pdm_stereo_rx.sv
`timescale 1ns/1ps
module sim_pdm_stereo_rx;

    localparam int CLK_PERIOD = 10;
    localparam int MEAS_EDGES = 4;
    localparam int LO_MIN = 40, LO_MAX = 80, HI_MIN = 16, HI_MAX = 30;

    logic clk = 0, rst = 1, pclk = 0, pdat = 0;
    logic [1:0] mode = 2'b00;
    logic smp_valid, rate_bad, mix_reject;
    logic [1:0] smp_code;

    int n_checks = 0, n_err = 0;
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdm_stereo_rx #(
        .SYNC_STAGES(2), .MEAS_EDGES(MEAS_EDGES),
        .LO_MIN(LO_MIN), .LO_MAX(LO_MAX), .HI_MIN(HI_MIN), .HI_MAX(HI_MAX)
    ) u0 (
        .clk_i(clk), .rst_i(rst), .pdm_clk_i(pclk), .pdm_dat_i(pdat),
        .mode_i(mode), .smp_valid_o(smp_valid), .smp_code_o(smp_code),
        .rate_bad_o(rate_bad), .mix_reject_o(mix_reject)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: histories of sampled inputs, rise times in integers
    int  hc[4], hd[3];
    int  m = 0, start_m = 0, edges = 0, band = 0, left_b = 0;
    bit  armed = 0, have_left = 0, e_valid = 0;
    int  e_code = 0;
    string e_tag = "R3";

    function automatic int classify(input int span);
        if (span >= LO_MIN && span <= LO_MAX) return 1;
        if (span >= HI_MIN && span <= HI_MAX) return 2;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (hc[i]) hc[i] = 0;
            foreach (hd[i]) hd[i] = 0;
            armed = 0; have_left = 0; band = 0; e_valid = 0; e_code = 0; edges = 0;
        end else begin
            bit rise, fall;
            int b, old_band;
            hc[3] = hc[2]; hc[2] = hc[1]; hc[1] = hc[0]; hc[0] = int'(pclk);
            hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = int'(pdat);
            m++;
            rise = (hc[2] == 1) && (hc[3] == 0);
            fall = (hc[2] == 0) && (hc[3] == 1);
            b = hd[2];
            e_valid = 0;
            case (mode)
                2'b01: e_tag = "R3";
                2'b10: e_tag = "R4";
                2'b11: e_tag = "R5";
                default: e_tag = "R7";
            endcase
            if (mode == 2'b00) begin
                armed = 0; have_left = 0; band = 0; edges = 0; left_b = 0; e_code = 0;
            end else begin
                old_band = band;
                if (rise) begin
                    left_b = b; have_left = 1;
                    if (mode == 2'b01) begin e_valid = 1; e_code = 2 * b; end
                end
                if (fall) begin
                    if (mode == 2'b10) begin e_valid = 1; e_code = 2 * b; end
                    else if (mode == 2'b11 && have_left && old_band != 2) begin
                        e_valid = 1; e_code = left_b + b;
                    end
                    have_left = 0;
                end
                if (rise) begin
                    if (!armed) begin armed = 1; start_m = m; edges = 0; end
                    else begin
                        edges++;
                        if (edges == MEAS_EDGES) begin
                            band = classify(m - start_m); start_m = m; edges = 0;
                        end
                    end
                end else if (armed && (m - start_m) > LO_MAX) begin
                    band = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(smp_valid == e_valid, e_tag, "valid", int'(smp_valid), int'(e_valid));
            if (e_valid) chk(int'(smp_code) == e_code, e_tag, "code", int'(smp_code), e_code);
            chk(rate_bad == (band == 0), "R8", "rate_bad", int'(rate_bad), int'(band == 0));
            chk(mix_reject == (mode == 2'b11 && band == 2), "R6", "mix_reject",
                int'(mix_reject), int'(mode == 2'b11 && band == 2));
        end
    end

    // Stimulus
    task automatic frames(input int half, input int n, input int pat);
        @(posedge clk);
        for (int i = 0; i < n; i++) begin
            logic l, r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (pat)
                0: begin l = lfsr[0]; r = lfsr[5]; end
                1: begin l = i[0]; r = i[1]; end
                default: begin l = 1'b1; r = 1'b1; end
            endcase
            #1; pclk = 1; pdat = l;
            repeat (half) @(posedge clk);
            #1; pclk = 0; pdat = r;
            repeat (half) @(posedge clk);
        end
    endtask

    task automatic set_mode(input logic [1:0] md);
        @(posedge clk); #1; mode = md;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(!smp_valid, "R1", "valid in reset", int'(smp_valid), 0);
        chk(rate_bad, "R1", "rate_bad in reset", int'(rate_bad), 1);
        chk(!mix_reject, "R1", "mix_reject in reset", int'(mix_reject), 0);
        @(posedge clk); #1; rst = 0;
        @(negedge clk);
        chk(!smp_valid && rate_bad && !mix_reject, "R1", "state after reset",
            int'({smp_valid, rate_bad, mix_reject}), 3'b010);

        // R3: left channel, low band
        set_mode(2'b01);
        frames(6, 12, 0);
        @(negedge clk);
        chk(!rate_bad, "R8", "low band verdict", int'(rate_bad), 0);

        // R4: right channel
        set_mode(2'b10);
        frames(6, 10, 0);
        frames(6, 4, 2);

        // R5: halved sum, all four left/right combinations
        set_mode(2'b11);
        frames(6, 12, 1);
        frames(6, 8, 0);
        @(negedge clk);
        chk(!mix_reject, "R6", "mix allowed in low band", int'(mix_reject), 0);

        // R6: jump into the high band while mixing
        frames(3, 16, 0);
        @(negedge clk);
        chk(mix_reject, "R6", "mix refused in high band", int'(mix_reject), 1);
        chk(!rate_bad, "R8", "high band verdict", int'(rate_bad), 0);

        // left in high band, then gap between bands
        set_mode(2'b01);
        frames(3, 8, 0);
        frames(4, 12, 0);
        @(negedge clk);
        chk(rate_bad, "R8", "gap between bands", int'(rate_bad), 1);
        frames(1, 16, 0);
        @(negedge clk);
        chk(rate_bad, "R8", "clock too fast", int'(rate_bad), 1);
        frames(12, 8, 0);
        @(negedge clk);
        chk(rate_bad, "R8", "clock too slow", int'(rate_bad), 1);

        // R9: stopped clock
        frames(6, 10, 0);
        @(negedge clk);
        chk(!rate_bad, "R9", "low band before stop", int'(rate_bad), 0);
        idle(100);
        @(negedge clk);
        chk(rate_bad, "R9", "stopped clock flagged", int'(rate_bad), 1);

        // R7: off clears measurement
        frames(6, 10, 0);
        set_mode(2'b00);
        frames(6, 4, 2);
        @(negedge clk);
        chk(!smp_valid && rate_bad, "R7", "off quiet", int'({smp_valid, rate_bad}), 1);
        set_mode(2'b01);
        frames(6, 3, 0);
        @(negedge clk);
        chk(rate_bad, "R7", "measurement restarted", int'(rate_bad), 1);
        frames(6, 8, 0);
        @(negedge clk);
        chk(!rate_bad, "R7", "new window timed", int'(rate_bad), 0);

        // R2: latency of a left strobe
        idle(4);
        @(posedge clk); #1; pclk = 1; pdat = 1;
        @(posedge clk);               // edge n captures the level
        @(negedge clk);
        chk(!smp_valid, "R2", "no strobe after n", int'(smp_valid), 0);
        @(posedge clk); @(negedge clk);
        chk(!smp_valid, "R2", "no strobe after n+1", int'(smp_valid), 0);
        @(posedge clk); @(negedge clk);
        chk(smp_valid && smp_code == 2'b10, "R2", "strobe after n+2",
            int'({smp_valid, smp_code}), 3'b110);
        @(posedge clk); #1; pclk = 0;
        idle(8);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_err++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

endmodule